// File: doc/BRIEF.md
# Repeat-Area DMA Source Address Generator

This block produces the source address sequence of one DMA channel. A transfer engine pulses a step strobe once per transfer. The block presents the address for the next transfer and then advances it by one byte. A 5-bit area code N confines the advance to the low N address bits. Those bits wrap to zero when they pass the end of a 2^N-byte window, and the bits above the window keep their value. Code 0 turns the window off, and the address then counts up freely.

A wrap of the window can raise an interrupt request, if interrupts are enabled. In single-transfer mode the request rises on the step that wraps. In block mode the channel moves data in blocks of a programmed length, taken from an 8-bit size field. A wrap inside a block is remembered, and the request is raised only when that block completes, so the block runs past the wrap point. While the request is high, the channel is halted: strobes are ignored until a restart reloads the start address and clears the request.

Top module: `dma_rpt_addr_gen`

## Requirements
- R1: After reset, `addr_o` is 0, and `blk_done_o` and `ovf_irq_o` are 0.
- R2: A cycle with `restart_i` high loads `start_addr_i` into `addr_o`, clears `ovf_irq_o` and any held overflow, and returns to the start of a block, all visible the next cycle. A strobe in the same cycle is discarded.
- R3: With area code N in 1..23, each accepted step adds one modulo 2^N to the low N bits of `addr_o` and leaves the higher bits unchanged. A code of 24 or more wraps the whole address. Example: N=3 from 0x240007 gives 0x240000.
- R4: With area code 0, each accepted step adds one to `addr_o` modulo 2^24, and `ovf_irq_o` never rises.
- R5: In single-transfer mode (`blk_mode_i`=0) with `irq_en_i`=1, a step taken at the last byte of the window sets `ovf_irq_o` in the next cycle, together with the wrapped address.
- R6: In block mode (`blk_mode_i`=1), `blk_done_o` is high for exactly one cycle after the step that completes a block of `blk_size_i` steps. A size of 0 means 256 steps. In single-transfer mode, `blk_done_o` stays 0.
- R7: In block mode with `irq_en_i`=1, a wrap on any step of a block sets `ovf_irq_o` only in the cycle in which `blk_done_o` pulses for that block. Example: start 0x240000, N=3, size 5. The first block covers 0x240000 to 0x240004 and raises no interrupt. The second block covers 0x240005, 0x240006, 0x240007, 0x240000 and 0x240001, and its completion raises the interrupt with `addr_o` = 0x240002.
- R8: While `ovf_irq_o` is high, steps do not change `addr_o`, do not pulse `blk_done_o`, and do not clear the request. Only a restart ends this state.
- R9: With `irq_en_i`=0, wraps still fold the address but never set `ovf_irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Reload the start address and clear the interrupt state |
| start_addr_i | input | 24 | Address loaded on restart |
| area_code_i | input | 5 | Window size code N; the window is 2^N bytes, and 0 turns it off |
| blk_size_i | input | 8 | Steps per block in block mode; 0 means 256 |
| blk_mode_i | input | 1 | 1 selects block mode, 0 selects single-transfer mode |
| irq_en_i | input | 1 | Enables the overflow interrupt request |
| step_i | input | 1 | One transfer done at `addr_o`; advance the address |
| addr_o | output | 24 | Address for the next transfer |
| blk_done_o | output | 1 | One-cycle pulse when a block completes |
| ovf_irq_o | output | 1 | Overflow interrupt request; halts stepping while set |

## Verification
Each piece of internal state reaches the ports within one cycle of the step that uses it. A wrong window mask changes the upper bits of `addr_o`, or leaves them unwrapped, right after the faulty step. A miscounted block position moves the `blk_done_o` pulse by at least one step. A lost or stuck held overflow shows up as `ovf_irq_o` rising at the wrong block boundary, or not at all. The bench sweeps area codes 0 to 5, both modes, both interrupt settings, several block sizes and start offsets, and compares all three outputs after every cycle against an arithmetic model.

// File: rtl/dma_rpt_addr_pkg.sv
package dma_rpt_addr_pkg;

    typedef enum logic {
        XFER_SINGLE = 1'b0,
        XFER_BLOCK  = 1'b1
    } xfer_mode_e;

    // Requests an interrupt when one is enabled and a wrap is to be reported.
    function automatic logic irq_fire(input logic enable, input logic wrapped);
        return enable & wrapped;
    endfunction

endpackage

// File: rtl/rpt_mask_gen.sv
// Builds the window mask: bit g is set when the area code exceeds g.
module rpt_mask_gen #(
    parameter int ADDR_W = 24,
    parameter int CODE_W = 5
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [ADDR_W-1:0] mask_o
);
    for (genvar g = 0; g < ADDR_W; g++) begin : g_bit
        assign mask_o[g] = (32'(code_i) > g);
    end
endmodule

// File: rtl/rpt_addr_step.sv
// Computes the next address inside the window and flags a wrap.
module rpt_addr_step #(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] mask_i,
    output logic [ADDR_W-1:0] next_o,
    output logic              wrap_o
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] inc;
    logic              area_on;

    always_comb begin
        inc     = addr_i + ONE;
        area_on = |mask_i;
        wrap_o  = area_on && ((addr_i & mask_i) == mask_i);
        if (area_on) begin
            next_o = (addr_i & ~mask_i) | (inc & mask_i);
        end else begin
            next_o = inc;
        end
    end
endmodule

// File: rtl/blk_tracker.sv
// Position inside a block; a size of zero gives the full 2^BLK_W steps.
module blk_tracker #(
    parameter int BLK_W = 8
) (
    input  logic [BLK_W-1:0] cnt_i,
    input  logic [BLK_W-1:0] size_i,
    output logic             last_o,
    output logic [BLK_W-1:0] cnt_inc_o
);
    localparam logic [BLK_W-1:0] ONE = {{(BLK_W-1){1'b0}}, 1'b1};

    always_comb begin
        last_o    = (cnt_i == (size_i - ONE));
        cnt_inc_o = cnt_i + ONE;
    end
endmodule

// File: rtl/dma_rpt_addr_gen.sv
module dma_rpt_addr_gen
    import dma_rpt_addr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CODE_W = 5,
    parameter int BLK_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              restart_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [CODE_W-1:0] area_code_i,
    input  logic [BLK_W-1:0]  blk_size_i,
    input  logic              blk_mode_i,
    input  logic              irq_en_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              blk_done_o,
    output logic              ovf_irq_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BLK_W-1:0]  cnt;
        logic              pend;
        logic              irq;
        logic              done;
    } gen_state_t;

    gen_state_t st_d, st_q;

    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] next_addr;
    logic              wrap;
    logic              blk_last;
    logic [BLK_W-1:0]  cnt_inc;
    xfer_mode_e        mode;

    rpt_mask_gen #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) mask_i (
        .code_i (area_code_i),
        .mask_o (mask)
    );

    rpt_addr_step #(.ADDR_W(ADDR_W)) step_i_u (
        .addr_i (st_q.addr),
        .mask_i (mask),
        .next_o (next_addr),
        .wrap_o (wrap)
    );

    blk_tracker #(.BLK_W(BLK_W)) blk_i (
        .cnt_i     (st_q.cnt),
        .size_i    (blk_size_i),
        .last_o    (blk_last),
        .cnt_inc_o (cnt_inc)
    );

    assign mode = xfer_mode_e'(blk_mode_i);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (restart_i) begin
            st_d.addr = start_addr_i;
            st_d.cnt  = '0;
            st_d.pend = 1'b0;
            st_d.irq  = 1'b0;
        end else if (step_i && !st_q.irq) begin
            st_d.addr = next_addr;
            if (mode == XFER_BLOCK) begin
                if (blk_last) begin
                    st_d.cnt  = '0;
                    st_d.done = 1'b1;
                    st_d.irq  = irq_fire(irq_en_i, st_q.pend | wrap);
                    st_d.pend = 1'b0;
                end else begin
                    st_d.cnt  = cnt_inc;
                    st_d.pend = st_q.pend | irq_fire(irq_en_i, wrap);
                end
            end else begin
                st_d.irq = irq_fire(irq_en_i, wrap);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o     = st_q.addr;
    assign blk_done_o = st_q.done;
    assign ovf_irq_o  = st_q.irq;
endmodule

// File: rtl/dma_rpt_addr_gen_chk.sv
module dma_rpt_addr_gen_chk #(
    parameter int ADDR_W = 24,
    parameter int CODE_W = 5,
    parameter int BLK_W  = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              restart_i,
    input logic [ADDR_W-1:0] start_addr_i,
    input logic [CODE_W-1:0] area_code_i,
    input logic [BLK_W-1:0]  blk_size_i,
    input logic              blk_mode_i,
    input logic              irq_en_i,
    input logic              step_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              blk_done_o,
    input logic              ovf_irq_o
);
    assert_restart_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> (addr_o == $past(start_addr_i)) && !ovf_irq_o && !blk_done_o);

    assert_upper_fixed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !restart_i && !ovf_irq_o && area_code_i != '0)
        |=> ((addr_o >> $past(area_code_i)) == ($past(addr_o) >> $past(area_code_i))));

    assert_no_irq_open_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (area_code_i == '0 && !ovf_irq_o) |=> !ovf_irq_o);

    assert_no_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !blk_mode_i |=> !blk_done_o);

    assert_irq_at_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (blk_mode_i && !ovf_irq_o && !restart_i) |=> (ovf_irq_o -> blk_done_o));

    assert_halt_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_irq_o && !restart_i) |=> $stable(addr_o) && ovf_irq_o && !blk_done_o);

    assert_irq_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!irq_en_i && !ovf_irq_o) |=> !ovf_irq_o);

    assert_irq_needs_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ovf_irq_o && !step_i) |=> !ovf_irq_o);
endmodule

bind dma_rpt_addr_gen dma_rpt_addr_gen_chk #(
    .ADDR_W(ADDR_W), .CODE_W(CODE_W), .BLK_W(BLK_W)
) chk_u (.*);

// File: tb/dma_rpt_addr_gen_tb_top.sv
module dma_rpt_addr_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          restart = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [4:0]    code = '0;
    logic [7:0]    bsize = 8'd1;
    logic          bmode = 1'b0;
    logic          ien = 1'b0;
    logic          step = 1'b0;
    logic [AW-1:0] addr;
    logic          done;
    logic          irq;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;

    int exp_addr, exp_cnt;
    bit exp_pend, exp_irq, exp_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_rpt_addr_gen dut_i (
        .clk_i(clk), .rst_ni(rst_n), .restart_i(restart),
        .start_addr_i(start_addr), .area_code_i(code), .blk_size_i(bsize),
        .blk_mode_i(bmode), .irq_en_i(ien), .step_i(step),
        .addr_o(addr), .blk_done_o(done), .ovf_irq_o(irq)
    );

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                n_bad++;
                $display("FAIL watchdog: actual=%0d cycles expected<=200000", cycles);
                finish_run();
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h (code=%0d blk=%0b size=%0d en=%0b)",
                     tag, act, exp, code, bmode, bsize, ien);
        end
    endtask

    task automatic check_all(input bit halted_before);
        string atag, itag;
        atag = halted_before ? "R8" : (code == 0 ? "R4" : "R3");
        itag = (code == 0) ? "R4" : (!ien ? "R9" : (bmode ? "R7" : "R5"));
        chk(atag, int'(addr), exp_addr);
        chk(halted_before ? "R8" : "R6", int'(done), int'(exp_done));
        chk(itag, int'(irq), int'(exp_irq));
    endtask

    // Arithmetic model of one accepted step.
    task automatic model_step();
        int sz, off, lim;
        bit wrapped;
        exp_done = 0;
        if (exp_irq) return;
        if (code == 0) begin
            wrapped  = 0;
            exp_addr = (exp_addr + 1) % (1 << AW);
        end else begin
            sz       = 1 << code;
            off      = exp_addr % sz;
            wrapped  = (off == sz - 1);
            exp_addr = exp_addr - off + ((off + 1) % sz);
        end
        if (bmode) begin
            lim = (bsize == 0) ? 256 : int'(bsize);
            if (exp_cnt + 1 == lim) begin
                exp_cnt  = 0;
                exp_done = 1;
                exp_irq  = ien && (exp_pend || wrapped);
                exp_pend = 0;
            end else begin
                exp_cnt++;
                if (ien && wrapped) exp_pend = 1;
            end
        end else begin
            exp_irq = ien && wrapped;
        end
    endtask

    task automatic cycle(input bit do_step);
        bit halted;
        halted = exp_irq;
        step = do_step;
        @(posedge clk);
        @(negedge clk);
        step = 1'b0;
        if (do_step) model_step();
        else exp_done = 0;
        check_all(halted && do_step);
    endtask

    task automatic do_restart(input int sa);
        start_addr = AW'(sa);
        restart = 1'b1;
        step = 1'b1;  // discarded: restart wins
        @(posedge clk);
        @(negedge clk);
        restart = 1'b0;
        step = 1'b0;
        exp_addr = sa; exp_cnt = 0; exp_pend = 0; exp_irq = 0; exp_done = 0;
        chk("R2", int'(addr), sa);
        chk("R2", int'(irq), 0);
        chk("R2", int'(done), 0);
    endtask

    initial begin
        int starts[3];
        int sizes[6];
        starts = '{32'h240000, 32'h23FFFE, 32'hFFFFFC};
        sizes  = '{1, 2, 3, 5, 8, 0};
        repeat (3) @(negedge clk);
        chk("R1", int'(addr), 0);
        chk("R1", int'(done), 0);
        chk("R1", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed case: 8-byte window, block size 5, block mode.
        code = 5'd3; bsize = 8'd5; bmode = 1'b1; ien = 1'b1;
        do_restart(32'h240000);
        for (int k = 0; k < 5; k++) cycle(1'b1);
        chk("R7", int'(addr), 32'h240005);
        chk("R7", int'(irq), 0);
        for (int k = 0; k < 5; k++) cycle(1'b1);
        chk("R7", int'(addr), 32'h240002);
        chk("R7", int'(irq), 1);
        cycle(1'b1);
        chk("R8", int'(addr), 32'h240002);

        for (int c = 0; c <= 5; c++) begin
            for (int m = 0; m < 2; m++) begin
                for (int e = 0; e < 2; e++) begin
                    for (int s = 0; s < 6; s++) begin
                        for (int a = 0; a < 3; a++) begin
                            code = 5'(c); bmode = m[0]; ien = e[0];
                            bsize = 8'(sizes[s]);
                            do_restart(starts[a]);
                            for (int k = 0; k < 36; k++) cycle(((k + a) % 4) != 3);
                        end
                    end
                end
            end
        end
        finish_run();
    end
endmodule